// File: doc/BRIEF.md
# Outstanding Cache Miss Request Tracker

The tracker sits between a second-level cache controller and the system bus. It keeps the block read requests and the dirty-victim writebacks that are in flight on the bus. Each miss request carries a block address with the 64-byte offset already removed, a request kind and the coherence state the line holds now. The tracker decides whether the request needs a bus read at all. If it does, it picks read-to-share or read-to-own, allocates a slot and presents the request on a registered issue port. Writebacks have their own slot table and their own issue port. A completion names a table and a slot index and frees that slot.

Read requests that find no free slot wait in a small in-order queue. A prefetch that the cache can already satisfy, or that duplicates a read already in flight or already queued, is retired on the spot with a one-cycle pulse and reaches the bus neither now nor later. One stall output tells the requester to hold both request inputs.

Top module: `outstanding_miss_tracker`

## Requirements
- R1: At most 3 read slots, indices 0..2. A new read takes the lowest-numbered free slot, and `rdIssueSlot` reports that index.
- R2: At most 2 writeback slots, indices 0..1, kept apart from the read slots. An accepted writeback takes the lowest free slot and appears on the writeback issue port one cycle after acceptance.
- R3: The kind encoding is load=0, store=1, read-intent prefetch=2 and write-intent prefetch=3. Loads and read-intent prefetches issue read-to-share (`rdIssueOwn`=0). Stores and write-intent prefetches issue read-to-own (`rdIssueOwn`=1).
- R4: The line states are Modified=0, Owned=1, Exclusive=2, Shared=3 and Invalid=4. A read-intent prefetch to a line that is not Invalid is retired (`pfRetire` pulses one cycle later) and issues nothing.
- R5: A write-intent prefetch to a Modified or Exclusive line is retired and issues nothing. In Owned, Shared or Invalid state it issues read-to-own.
- R6: A prefetch whose block address equals that of a busy read slot or a queued read is retired and issues nothing. Loads and stores are never matched.
- R7: A read that finds no free slot, or finds reads already queued, waits in a 2-entry queue. Queued reads issue oldest first, in the cycle after the cycle in which the freeing completion is presented.
- R8: `stall` is high while the queue holds 2 reads or both writeback slots are busy. A request presented while `stall` is high is ignored.
- R9: A read that is accepted while a slot is free and the queue is empty appears on the read issue port one cycle after acceptance. A completion frees the slot it names.
- R10: After reset, `stall`, `rdIssueValid`, `wbIssueValid` and `pfRetire` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Miss request present |
| reqKind | input | 2 | Request kind (R3 encoding) |
| reqState | input | 3 | Current line state (R4 encoding) |
| reqAddr | input | BLK_W | Block address |
| wbReqValid | input | 1 | Writeback request present |
| wbReqAddr | input | BLK_W | Writeback block address |
| cmpValid | input | 1 | Bus completion present |
| cmpIsWb | input | 1 | Completion targets the writeback table |
| cmpSlot | input | CMP_W | Slot index being completed |
| stall | output | 1 | Hold both request inputs |
| rdIssueValid | output | 1 | Read request issued this cycle |
| rdIssueOwn | output | 1 | 1 = read-to-own, 0 = read-to-share |
| rdIssueAddr | output | BLK_W | Issued read block address |
| rdIssueSlot | output | RD_IDX_W | Read slot of the issued request |
| wbIssueValid | output | 1 | Writeback issued this cycle |
| wbIssueAddr | output | BLK_W | Issued writeback block address |
| wbIssueSlot | output | WB_IDX_W | Writeback slot of the issued request |
| pfRetire | output | 1 | A prefetch was retired without a bus request |

## Verification
A direct read, a writeback and a prefetch retirement each show on their port exactly one cycle after the cycle in which the request is presented. A queued read shows two cycles after the cycle in which the freeing completion is presented. When the driver presents a stimulus it stamps every expected item with its due cycle, computed from these latencies and the bench's own cycle counter. The monitor samples on the falling edge and compares address, opcode, slot and cycle against the oldest expectation. It flags an issue that nobody expected, and an expectation whose cycle passes with nothing on the port. Ignored requests are covered by the absence of any matching issue in the cycles after them.

// File: rtl/omt_pkg.sv
package omt_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_PF_RD = 2'd2,
    KIND_PF_WR = 2'd3
  } reqKind_e;

  localparam logic [2:0] LS_MOD = 3'd0;
  localparam logic [2:0] LS_OWN = 3'd1;
  localparam logic [2:0] LS_EXC = 3'd2;
  localparam logic [2:0] LS_SHR = 3'd3;
  localparam logic [2:0] LS_INV = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic rdIssue;
    logic rdFromQ;
    logic qPush;
    logic qPop;
    logic wbIssue;
    logic pfRetire;
  } omtStrobe_t;

endpackage

// File: rtl/omt_ctrl.sv
module omt_ctrl
  import omt_pkg::*;
#(
  parameter int RD_SLOTS = 3,
  parameter int WB_SLOTS = 2,
  parameter int Q_DEPTH  = 2,
  parameter int RD_IDX_W = 2,
  parameter int WB_IDX_W = 1,
  parameter int Q_CNT_W  = 2,
  parameter int CMP_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  input  logic [1:0]          reqKind,
  input  logic [2:0]          reqState,
  input  logic                wbReqValid,
  input  logic                cmpValid,
  input  logic                cmpIsWb,
  input  logic [CMP_W-1:0]    cmpSlot,
  input  logic                dupHit,
  output omtStrobe_t          strb,
  output logic [RD_IDX_W-1:0] rdSlot,
  output logic [WB_IDX_W-1:0] wbSlot,
  output logic [Q_CNT_W-1:0]  qPushIdx,
  output logic [RD_SLOTS-1:0] rdBusy,
  output logic [Q_CNT_W-1:0]  qCount,
  output logic                stall
);

  logic [WB_SLOTS-1:0] wbBusy;
  logic [RD_SLOTS-1:0] rdBusyNext;
  logic [WB_SLOTS-1:0] wbBusyNext;
  logic                rdFreeAny;
  logic                wbFreeAny;
  logic                accept;
  logic                cacheHit;
  logic                drop;
  logic                needRd;
  logic                qNonEmpty;
  reqKind_e            kindE;

  assign kindE     = reqKind_e'(reqKind);
  assign stall     = (qCount == Q_CNT_W'(Q_DEPTH)) || (&wbBusy);
  assign accept    = reqValid && !stall;
  assign qNonEmpty = (qCount != '0);

  always_comb begin
    cacheHit = 1'b0;
    if (kindE == KIND_PF_RD) cacheHit = (reqState != LS_INV);
    if (kindE == KIND_PF_WR) cacheHit = (reqState == LS_MOD) || (reqState == LS_EXC);
  end

  assign drop   = accept && reqKind[1] && (cacheHit || dupHit);
  assign needRd = accept && !drop;

  // lowest-index free slot search
  always_comb begin
    rdFreeAny = 1'b0;
    rdSlot    = '0;
    for (int i = RD_SLOTS - 1; i >= 0; i--) begin
      if (!rdBusy[i]) begin
        rdFreeAny = 1'b1;
        rdSlot    = RD_IDX_W'(i);
      end
    end
  end

  always_comb begin
    wbFreeAny = 1'b0;
    wbSlot    = '0;
    for (int i = WB_SLOTS - 1; i >= 0; i--) begin
      if (!wbBusy[i]) begin
        wbFreeAny = 1'b1;
        wbSlot    = WB_IDX_W'(i);
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.rdFromQ  = qNonEmpty;
    strb.rdIssue  = rdFreeAny && (qNonEmpty || needRd);
    strb.qPop     = rdFreeAny && qNonEmpty;
    strb.qPush    = needRd && (qNonEmpty || !rdFreeAny);
    strb.wbIssue  = wbReqValid && !stall && wbFreeAny;
    strb.pfRetire = drop;
  end

  assign qPushIdx = qCount - Q_CNT_W'(strb.qPop);

  always_comb begin
    rdBusyNext = rdBusy;
    for (int i = 0; i < RD_SLOTS; i++) begin
      if (cmpValid && !cmpIsWb && cmpSlot == CMP_W'(i)) rdBusyNext[i] = 1'b0;
      if (strb.rdIssue && rdSlot == RD_IDX_W'(i))       rdBusyNext[i] = 1'b1;
    end
  end

  always_comb begin
    wbBusyNext = wbBusy;
    for (int i = 0; i < WB_SLOTS; i++) begin
      if (cmpValid && cmpIsWb && cmpSlot == CMP_W'(i)) wbBusyNext[i] = 1'b0;
      if (strb.wbIssue && wbSlot == WB_IDX_W'(i))      wbBusyNext[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdBusy <= '0;
      wbBusy <= '0;
      qCount <= '0;
    end else begin
      rdBusy <= rdBusyNext;
      wbBusy <= wbBusyNext;
      qCount <= qCount + Q_CNT_W'(strb.qPush) - Q_CNT_W'(strb.qPop);
    end
  end

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(qCount) <= Q_DEPTH); // R7

  AST_STALL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> qCount <= $past(qCount)); // R8

  AST_ALLOC_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rdIssue |=> rdBusy[$past(rdSlot)]); // R1

endmodule

// File: rtl/omt_datapath.sv
module omt_datapath
  import omt_pkg::*;
#(
  parameter int RD_SLOTS = 3,
  parameter int Q_DEPTH  = 2,
  parameter int BLK_W    = 34,
  parameter int RD_IDX_W = 2,
  parameter int WB_IDX_W = 1,
  parameter int Q_CNT_W  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  omtStrobe_t          strb,
  input  logic [BLK_W-1:0]    reqAddr,
  input  logic                reqOwn,
  input  logic [BLK_W-1:0]    wbReqAddr,
  input  logic [RD_IDX_W-1:0] rdSlot,
  input  logic [WB_IDX_W-1:0] wbSlot,
  input  logic [Q_CNT_W-1:0]  qPushIdx,
  input  logic [RD_SLOTS-1:0] rdBusy,
  input  logic [Q_CNT_W-1:0]  qCount,
  output logic                dupHit,
  output logic                rdIssueValid,
  output logic                rdIssueOwn,
  output logic [BLK_W-1:0]    rdIssueAddr,
  output logic [RD_IDX_W-1:0] rdIssueSlot,
  output logic                wbIssueValid,
  output logic [BLK_W-1:0]    wbIssueAddr,
  output logic [WB_IDX_W-1:0] wbIssueSlot,
  output logic                pfRetire
);

  logic [BLK_W-1:0] slotAddr [RD_SLOTS];
  logic [BLK_W-1:0] qAddr    [Q_DEPTH];
  logic             qOwn     [Q_DEPTH];
  logic [BLK_W-1:0] qShAddr  [Q_DEPTH];
  logic             qShOwn   [Q_DEPTH];
  logic [BLK_W-1:0] issueAddr;
  logic             issueOwn;

  // queue contents shifted by one toward the head
  for (genvar j = 0; j < Q_DEPTH; j++) begin : g_shift
    if (j < Q_DEPTH - 1) begin : g_mid
      assign qShAddr[j] = qAddr[j+1];
      assign qShOwn[j]  = qOwn[j+1];
    end else begin : g_tail
      assign qShAddr[j] = '0;
      assign qShOwn[j]  = 1'b0;
    end
  end

  always_comb begin
    dupHit = 1'b0;
    for (int i = 0; i < RD_SLOTS; i++)
      if (rdBusy[i] && slotAddr[i] == reqAddr) dupHit = 1'b1;
    for (int j = 0; j < Q_DEPTH; j++)
      if (Q_CNT_W'(j) < qCount && qAddr[j] == reqAddr) dupHit = 1'b1;
  end

  assign issueAddr = strb.rdFromQ ? qAddr[0] : reqAddr;
  assign issueOwn  = strb.rdFromQ ? qOwn[0]  : reqOwn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RD_SLOTS; i++) slotAddr[i] <= '0;
      for (int j = 0; j < Q_DEPTH; j++) begin
        qAddr[j] <= '0;
        qOwn[j]  <= 1'b0;
      end
    end else begin
      for (int i = 0; i < RD_SLOTS; i++)
        if (strb.rdIssue && rdSlot == RD_IDX_W'(i)) slotAddr[i] <= issueAddr;
      for (int j = 0; j < Q_DEPTH; j++) begin
        if (strb.qPush && qPushIdx == Q_CNT_W'(j)) begin
          qAddr[j] <= reqAddr;
          qOwn[j]  <= reqOwn;
        end else if (strb.qPop) begin
          qAddr[j] <= qShAddr[j];
          qOwn[j]  <= qShOwn[j];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdIssueValid <= 1'b0;
      rdIssueOwn   <= 1'b0;
      rdIssueAddr  <= '0;
      rdIssueSlot  <= '0;
      wbIssueValid <= 1'b0;
      wbIssueAddr  <= '0;
      wbIssueSlot  <= '0;
      pfRetire     <= 1'b0;
    end else begin
      rdIssueValid <= strb.rdIssue;
      wbIssueValid <= strb.wbIssue;
      pfRetire     <= strb.pfRetire;
      if (strb.rdIssue) begin
        rdIssueOwn  <= issueOwn;
        rdIssueAddr <= issueAddr;
        rdIssueSlot <= rdSlot;
      end
      if (strb.wbIssue) begin
        wbIssueAddr <= wbReqAddr;
        wbIssueSlot <= wbSlot;
      end
    end
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    strb.qPop |-> qCount != '0); // R7

  AST_ISSUE_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rdIssue |-> !rdBusy[rdSlot]); // R1

endmodule

// File: rtl/outstanding_miss_tracker.sv
module outstanding_miss_tracker
  import omt_pkg::*;
#(
  parameter int  RD_SLOTS = 3,
  parameter int  WB_SLOTS = 2,
  parameter int  Q_DEPTH  = 2,
  parameter int  BLK_W    = 34,
  localparam int RD_IDX_W = (RD_SLOTS > 1) ? $clog2(RD_SLOTS) : 1,
  localparam int WB_IDX_W = (WB_SLOTS > 1) ? $clog2(WB_SLOTS) : 1,
  localparam int Q_CNT_W  = $clog2(Q_DEPTH + 1),
  localparam int CMP_W    = (RD_IDX_W > WB_IDX_W) ? RD_IDX_W : WB_IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  input  logic [1:0]          reqKind,
  input  logic [2:0]          reqState,
  input  logic [BLK_W-1:0]    reqAddr,
  input  logic                wbReqValid,
  input  logic [BLK_W-1:0]    wbReqAddr,
  input  logic                cmpValid,
  input  logic                cmpIsWb,
  input  logic [CMP_W-1:0]    cmpSlot,
  output logic                stall,
  output logic                rdIssueValid,
  output logic                rdIssueOwn,
  output logic [BLK_W-1:0]    rdIssueAddr,
  output logic [RD_IDX_W-1:0] rdIssueSlot,
  output logic                wbIssueValid,
  output logic [BLK_W-1:0]    wbIssueAddr,
  output logic [WB_IDX_W-1:0] wbIssueSlot,
  output logic                pfRetire
);

  omtStrobe_t          strb;
  logic [RD_IDX_W-1:0] rdSlot;
  logic [WB_IDX_W-1:0] wbSlot;
  logic [Q_CNT_W-1:0]  qPushIdx;
  logic [RD_SLOTS-1:0] rdBusy;
  logic [Q_CNT_W-1:0]  qCount;
  logic                dupHit;

  omt_ctrl #(
    .RD_SLOTS(RD_SLOTS), .WB_SLOTS(WB_SLOTS), .Q_DEPTH(Q_DEPTH),
    .RD_IDX_W(RD_IDX_W), .WB_IDX_W(WB_IDX_W), .Q_CNT_W(Q_CNT_W), .CMP_W(CMP_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqKind(reqKind),
    .reqState(reqState), .wbReqValid(wbReqValid), .cmpValid(cmpValid),
    .cmpIsWb(cmpIsWb), .cmpSlot(cmpSlot), .dupHit(dupHit), .strb(strb),
    .rdSlot(rdSlot), .wbSlot(wbSlot), .qPushIdx(qPushIdx), .rdBusy(rdBusy),
    .qCount(qCount), .stall(stall)
  );

  omt_datapath #(
    .RD_SLOTS(RD_SLOTS), .Q_DEPTH(Q_DEPTH), .BLK_W(BLK_W),
    .RD_IDX_W(RD_IDX_W), .WB_IDX_W(WB_IDX_W), .Q_CNT_W(Q_CNT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .reqAddr(reqAddr),
    .reqOwn(reqKind[0]), .wbReqAddr(wbReqAddr), .rdSlot(rdSlot),
    .wbSlot(wbSlot), .qPushIdx(qPushIdx), .rdBusy(rdBusy), .qCount(qCount),
    .dupHit(dupHit), .rdIssueValid(rdIssueValid), .rdIssueOwn(rdIssueOwn),
    .rdIssueAddr(rdIssueAddr), .rdIssueSlot(rdIssueSlot),
    .wbIssueValid(wbIssueValid), .wbIssueAddr(wbIssueAddr),
    .wbIssueSlot(wbIssueSlot), .pfRetire(pfRetire)
  );

  AST_WB_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wbReqValid && !stall |=> wbIssueValid); // R2

  AST_RD_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rdIssueValid |-> int'(rdIssueSlot) < RD_SLOTS); // R1

endmodule

// File: tb/outstanding_miss_tracker_test.sv
module outstanding_miss_tracker_test;

  localparam int CLK_PERIOD = 10;
  localparam int BW = 34;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqKind = '0;
  logic [2:0]    reqState = '0;
  logic [BW-1:0] reqAddr = '0;
  logic          wbReqValid = 1'b0;
  logic [BW-1:0] wbReqAddr = '0;
  logic          cmpValid = 1'b0;
  logic          cmpIsWb = 1'b0;
  logic [1:0]    cmpSlot = '0;
  logic          stall, rdIssueValid, rdIssueOwn, wbIssueValid, pfRetire;
  logic [BW-1:0] rdIssueAddr, wbIssueAddr;
  logic [1:0]    rdIssueSlot;
  logic [0:0]    wbIssueSlot;

  outstanding_miss_tracker uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqKind(reqKind),
    .reqState(reqState), .reqAddr(reqAddr), .wbReqValid(wbReqValid),
    .wbReqAddr(wbReqAddr), .cmpValid(cmpValid), .cmpIsWb(cmpIsWb),
    .cmpSlot(cmpSlot), .stall(stall), .rdIssueValid(rdIssueValid),
    .rdIssueOwn(rdIssueOwn), .rdIssueAddr(rdIssueAddr),
    .rdIssueSlot(rdIssueSlot), .wbIssueValid(wbIssueValid),
    .wbIssueAddr(wbIssueAddr), .wbIssueSlot(wbIssueSlot), .pfRetire(pfRetire)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [BW-1:0] addr;
    logic          own;
    int            slot;
    int            due;
    string         req;
  } exp_t;

  exp_t  rdQ[$];
  exp_t  wbQ[$];
  exp_t  retQ[$];
  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // driver side: expectations stamped with their due cycle
  function automatic void expectRd(logic [BW-1:0] a, logic o, int s, int d, string r);
    rdQ.push_back('{a, o, s, cyc + d, r});
  endfunction
  function automatic void expectWb(logic [BW-1:0] a, int s, string r);
    wbQ.push_back('{a, 1'b0, s, cyc + 1, r});
  endfunction
  function automatic void expectRet(string r);
    retQ.push_back('{'0, 1'b0, 0, cyc + 1, r});
  endfunction

  task automatic send(logic [1:0] k, logic [BW-1:0] a, logic [2:0] st);
    reqValid = 1'b1; reqKind = k; reqAddr = a; reqState = st;
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask
  task automatic sendWb(logic [BW-1:0] a);
    wbReqValid = 1'b1; wbReqAddr = a;
    @(posedge clk); #1;
    wbReqValid = 1'b0;
  endtask
  task automatic doCmp(logic isWb, int s);
    cmpValid = 1'b1; cmpIsWb = isWb; cmpSlot = 2'(s);
    @(posedge clk); #1;
    cmpValid = 1'b0;
  endtask
  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic checkStall(logic exp, string r);
    @(negedge clk);
    check(r, "stall", stall, exp);
    @(posedge clk); #1;
  endtask

  // monitor: pops and compares as results appear
  always @(negedge clk) begin : monitor
    exp_t e;
    if (rst_n) begin
      if (rdIssueValid) begin
        if (rdQ.size() == 0) check("R1", "unexpected read issue addr", rdIssueAddr, -1);
        else begin
          e = rdQ.pop_front();
          check(e.req, "read addr", rdIssueAddr, e.addr);
          check(e.req, "read own", rdIssueOwn, e.own);
          check(e.req, "read slot", rdIssueSlot, e.slot);
          check(e.req, "read cycle", cyc, e.due);
        end
      end else if (rdQ.size() != 0 && rdQ[0].due <= cyc) begin
        e = rdQ.pop_front();
        check(e.req, "missing read issue", 0, 1);
      end
      if (wbIssueValid) begin
        if (wbQ.size() == 0) check("R2", "unexpected writeback issue addr", wbIssueAddr, -1);
        else begin
          e = wbQ.pop_front();
          check(e.req, "wb addr", wbIssueAddr, e.addr);
          check(e.req, "wb slot", wbIssueSlot, e.slot);
          check(e.req, "wb cycle", cyc, e.due);
        end
      end else if (wbQ.size() != 0 && wbQ[0].due <= cyc) begin
        e = wbQ.pop_front();
        check(e.req, "missing wb issue", 0, 1);
      end
      if (pfRetire) begin
        if (retQ.size() == 0) check("R6", "unexpected retire", 1, 0);
        else begin
          e = retQ.pop_front();
          check(e.req, "retire cycle", cyc, e.due);
        end
      end else if (retQ.size() != 0 && retQ[0].due <= cyc) begin
        e = retQ.pop_front();
        check(e.req, "missing retire", 0, 1);
      end
    end
  end

  localparam logic [1:0] K_LD = 2'd0, K_ST = 2'd1, K_PR = 2'd2, K_PW = 2'd3;
  localparam logic [2:0] S_M = 3'd0, S_O = 3'd1, S_E = 3'd2, S_S = 3'd3, S_I = 3'd4;

  initial begin : stimulus
    repeat (3) @(negedge clk);
    check("R10", "stall in reset", stall, 0);
    check("R10", "rdIssueValid in reset", rdIssueValid, 0);
    check("R10", "wbIssueValid in reset", wbIssueValid, 0);
    check("R10", "pfRetire in reset", pfRetire, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(1);
    checkStall(1'b0, "R10");

    expectRd(34'h100, 1'b0, 0, 1, "R3 load share R9");  send(K_LD, 34'h100, S_I);
    expectRd(34'h200, 1'b1, 1, 1, "R3 store own R1");   send(K_ST, 34'h200, S_S);
    expectRd(34'h300, 1'b1, 2, 1, "R5 pfwr shared");    send(K_PW, 34'h300, S_S);
    expectRet("R6 dup slot");                           send(K_PR, 34'h100, S_I);
    send(K_LD, 34'h400, S_I);                            // queued
    expectRet("R6 dup queue");                          send(K_PR, 34'h400, S_I);
    send(K_LD, 34'h500, S_I);                            // queued
    checkStall(1'b1, "R8 queue full");
    send(K_LD, 34'h600, S_I);                            // ignored under stall
    expectRd(34'h400, 1'b0, 1, 2, "R7 oldest first");   doCmp(1'b0, 1);
    expectRd(34'h500, 1'b0, 0, 2, "R7 second");         doCmp(1'b0, 0);
    idle(2);
    checkStall(1'b0, "R8 drained");

    expectRet("R4 pfrd shared");                        send(K_PR, 34'h900, S_S);
    expectRet("R5 pfwr modified");                      send(K_PW, 34'h900, S_M);
    expectRet("R5 pfwr exclusive");                     send(K_PW, 34'h900, S_E);
    expectRet("R6 dup refilled slot");                  send(K_PR, 34'h500, S_I);

    expectWb(34'hA00, 0, "R2 wb slot0");                sendWb(34'hA00);
    expectWb(34'hB00, 1, "R2 wb slot1");                sendWb(34'hB00);
    checkStall(1'b1, "R8 wb full");
    sendWb(34'hC00);                                     // ignored under stall
    doCmp(1'b1, 0);
    expectWb(34'hD00, 0, "R2 lowest free");             sendWb(34'hD00);
    doCmp(1'b1, 0);
    doCmp(1'b1, 1);
    idle(1);

    doCmp(1'b0, 1);
    doCmp(1'b0, 2);
    expectRd(34'hE00, 1'b0, 1, 1, "R1 lowest free");    send(K_LD, 34'hE00, S_I);
    expectRd(34'hE00, 1'b0, 2, 1, "R6 load not matched"); send(K_LD, 34'hE00, S_I);
    send(K_PW, 34'hF00, S_O);                            // queued, slots full
    expectRd(34'hF00, 1'b1, 0, 2, "R5 owned pfwr R7");  doCmp(1'b0, 0);
    idle(5);

    check("R1", "read expectations left", rdQ.size(), 0);
    check("R2", "wb expectations left", wbQ.size(), 0);
    check("R6", "retire expectations left", retQ.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule